// File: doc/BRIEF.md
# Toggle-Flag Parallel Bus Synchronizer

This block moves a parallel data byte that arrives with its own slow strobe clock into a fast system clock domain, without a dual-clock FIFO. On the source side, each rising strobe edge registers the byte and inverts a single flag bit. On the system side, the flag passes through a short flip-flop chain, and each change of the flag becomes exactly one new-data event.

The captured byte is then loaded into an output register. A one-cycle valid pulse goes with it, ready to drive the write port of a FIFO in the system domain.

Because each edge is detected by a change of the flag, not by sampling the strobe level, the strobe may have any duty cycle, even a very short high time. The source rate must stay well below the system rate. The captured byte has to stay unchanged until the output register has taken it, which is four enabled system cycles at the default depth.

Top module: `toggle_bus_sync`

## Requirements
- R1: On each rising edge of `src_clk`, the value on `src_data` is registered in the source domain and is later presented on `out_data` unchanged.
- R2: Each rising edge of `src_clk` produces exactly one `out_valid` pulse. With the default three-stage chain, `out_valid` is high after the fourth enabled rising edge of `clk` that follows the source edge.
- R3: `out_data` changes only on the cycle where it loads a new byte together with `out_valid`. Otherwise it holds its last value.
- R4: `out_valid` is high for a single enabled system cycle per source edge.
- R5: Capture is independent of the strobe duty cycle. A 2 ns high time and a 2 ns low time are both handled correctly.
- R6: While `en` is low, all system-domain state holds, including `out_valid` and `out_data`. Only enabled cycles count toward the latency of R2.
- R7: An active-low `rst_n` clears `out_valid` and `out_data` to zero at the next `clk` edge whatever the value of `en`. It clears the source flag and source byte at once.
- R8: No `out_valid` pulse appears after reset is released until a new source edge arrives.
- R9: Source edges spaced five system cycles apart each deliver their own byte in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; synchronous for system state, immediate for source state |
| en | input | 1 | System-domain clock enable |
| src_clk | input | 1 | Source strobe clock, rising edge active |
| src_data | input | 8 | Source data byte |
| out_valid | output | 1 | One-cycle pulse marking a newly delivered byte |
| out_data | output | 8 | Delivered byte, held between pulses |

## Verification
A fault in the resync chain or in the flag shows up at the ports as a missing, doubled or early `out_valid`. The bench catches it within four enabled cycles of the source edge, because a behavioural model predicts the exact cycle of every pulse. A stale or wrongly captured byte shows up in `out_data` on the same cycle as its pulse. A chain that does not freeze under a low `en` shifts the pulse earlier, and this is visible on the first enabled cycle after `en` returns high. A reset that leaves one stage uncleared produces a spurious pulse within three cycles of release.

// File: rtl/tbs_pkg.sv
// Package: shared defaults for the toggle-flag bus synchronizer.
// Assumes: nothing; constants only.
package tbs_pkg;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_STAGES = 3;
endpackage

// File: rtl/tbs_src_capture.sv
// Source-domain half: registers the byte and inverts the flag on each
// rising strobe edge.
// Assumes: the strobe may stop at any time, so reset clears this state
// without waiting for a strobe edge.
module tbs_src_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              src_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_data,
    output logic [DATA_W-1:0] cap_data,
    output logic              flag
);
    // Capture byte and invert flag on each source edge.
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_data <= '0;
            flag     <= 1'b0;
        end else begin
            cap_data <= src_data;
            flag     <= ~flag;
        end
    end
endmodule

// File: rtl/tbs_flag_resync.sv
// System-domain flag resynchroniser: shifts the source flag through
// STAGES flip-flops and registers the XOR of the last two stages as a
// one-cycle strobe per flag change.
// Assumes: STAGES >= 2. The flag changes at most once per STAGES+1
// enabled system cycles.
module tbs_flag_resync #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic flag_async,
    output logic strobe
);
    localparam int unsigned LAST = STAGES - 1;
    localparam int unsigned PREV = STAGES - 2;

    logic [STAGES-1:0] chain;

    // Shift the flag in; reset first, then the enable gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (en) begin
            chain <= {chain[STAGES-2:0], flag_async};
        end
    end

    // Register the change detector on the two oldest stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else if (en) begin
            strobe <= chain[LAST] ^ chain[PREV];
        end
    end
endmodule

// File: rtl/tbs_out_stage.sv
// Output register: loads the captured byte on a strobe and raises valid
// for one enabled cycle; holds everything while disabled.
// Assumes: cap_data is stable whenever strobe is high.
module tbs_out_stage #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              strobe,
    input  logic [DATA_W-1:0] cap_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Valid follows the strobe on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (en) begin
            out_valid <= strobe;
        end
    end

    // Data loads only with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (en && strobe) begin
            out_data <= cap_data;
        end
    end
endmodule

// File: rtl/toggle_bus_sync.sv
// Top: carries a strobe-clocked byte into the system domain through a
// toggling flag. Latency is STAGES+1 enabled system cycles.
// Assumes: the source edge rate is well below a quarter of the system
// rate, and src_clk is quiet while rst_n is released.
module toggle_bus_sync #(
    parameter int unsigned DATA_W = tbs_pkg::DEF_DATA_W,
    parameter int unsigned STAGES = tbs_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              src_clk,
    input  logic [DATA_W-1:0] src_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] cap_data;
    logic              flag;
    logic              strobe;

    tbs_src_capture #(.DATA_W(DATA_W)) u_cap (
        .src_clk  (src_clk),
        .rst_n    (rst_n),
        .src_data (src_data),
        .cap_data (cap_data),
        .flag     (flag)
    );

    tbs_flag_resync #(.STAGES(STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .flag_async (flag),
        .strobe     (strobe)
    );

    tbs_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .strobe    (strobe),
        .cap_data  (cap_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/toggle_bus_sync_chk.sv
// Checker: port-level timing properties of the synchronizer.
// Assumes: source edges are spaced as the top module requires.
module toggle_bus_sync_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> (out_valid == 1'b0 && out_data == '0));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && en) |=> !out_valid);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(out_valid) && $stable(out_data)));

    assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> !out_valid);
endmodule

bind toggle_bus_sync toggle_bus_sync_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/toggle_bus_sync_test.sv
// Bench: behavioural pending-event model compared on every clock.
module toggle_bus_sync_test;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       src_clk = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       out_valid;
    logic [7:0] out_data;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int sent = 0;
    bit done = 0;
    logic last_v = 1'b0;
    string tag_v = "R7";
    string tag_d = "R7";

    int         cnt_q[$];
    logic [7:0] byte_q[$];
    logic       exp_v = 1'b0;
    logic [7:0] exp_d = 8'h00;

    toggle_bus_sync uut (
        .clk(clk), .rst_n(rst_n), .en(en), .src_clk(src_clk),
        .src_data(src_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    // Model: each source edge matures after LAT enabled system edges.
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_q.delete(); byte_q.delete();
            exp_v = 1'b0; exp_d = 8'h00;
        end else if (en) begin
            exp_v = 1'b0;
            foreach (cnt_q[i]) cnt_q[i] = cnt_q[i] - 1;
            if (cnt_q.size() > 0 && cnt_q[0] == 0) begin
                exp_v = 1'b1;
                exp_d = byte_q[0];
                void'(cnt_q.pop_front());
                void'(byte_q.pop_front());
            end
        end
    end

    always @(posedge src_clk) begin
        if (rst_n) begin
            cnt_q.push_back(LAT);
            byte_q.push_back(src_data);
            sent++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            check(out_valid === exp_v, tag_v, out_valid, exp_v);
            check(out_data === exp_d, tag_d, out_data, exp_d);
            if (out_valid && !last_v) pulses++;
            last_v = out_valid;
        end
    end

    task automatic send(input logic [7:0] b, input int hi, input int lo);
        @(posedge clk);
        #3 src_data = b;
        #1 src_clk = 1'b1;
        #(hi) src_clk = 1'b0;
        #(lo);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic at_neg(output bit dummy);
        @(negedge clk); #1; dummy = 1'b1;
    endtask

    task automatic report();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        bit d;
        int p0;
        int s0;
        // R7: reset state
        idle(4);
        @(negedge clk);
        check(out_valid === 1'b0 && out_data === 8'h00, "R7 reset outputs", out_data, 0);
        #1 rst_n = 1'b1;
        // R8: quiet after release
        tag_v = "R8"; tag_d = "R8";
        idle(10);
        check(pulses == 0, "R8 pulses after reset", pulses, 0);

        // R1 R2 R3: plain bytes
        tag_v = "R2"; tag_d = "R1";
        p0 = pulses; s0 = sent;
        send(8'hA5, 30, 50); send(8'h3C, 30, 50); send(8'hFF, 30, 50);
        send(8'h00, 30, 50); send(8'h81, 30, 50);
        idle(10);
        check(pulses - p0 == 5 && sent - s0 == 5, "R2 pulse count", pulses - p0, 5);
        check(out_data === 8'h81, "R3 held last byte", out_data, 8'h81);

        // R5: asymmetric duty
        tag_v = "R5"; tag_d = "R5";
        p0 = pulses;
        send(8'h11, 2, 60); send(8'h22, 60, 2); send(8'h33, 2, 60);
        idle(10);
        check(pulses - p0 == 3, "R5 pulse count", pulses - p0, 3);

        // R9: minimum spacing, five system cycles
        tag_v = "R9"; tag_d = "R9";
        p0 = pulses;
        for (int i = 0; i < 6; i++) send(8'h40 + 8'(i * 7), 20, 21);
        idle(10);
        check(pulses - p0 == 6, "R9 pulse count", pulses - p0, 6);
        check(out_data === 8'h63, "R9 last byte", out_data, 8'h63);

        // R6: enable low while a byte is in flight
        tag_v = "R6"; tag_d = "R6";
        p0 = pulses;
        send(8'h5A, 10, 5);
        at_neg(d); en = 1'b0;
        idle(12);
        check(out_valid === 1'b0, "R6 frozen no pulse", out_valid, 0);
        at_neg(d); en = 1'b1;
        idle(8);
        check(pulses - p0 == 1 && out_data === 8'h5A, "R6 delayed delivery", out_data, 8'h5A);
        // R6 with valid frozen high
        send(8'hC3, 10, 5);
        while (!(out_valid === 1'b1)) @(negedge clk);
        #1 en = 1'b0;
        idle(5);
        check(out_valid === 1'b1, "R6 valid held", out_valid, 1);
        at_neg(d); en = 1'b1;
        idle(3);
        check(out_valid === 1'b0 && out_data === 8'hC3, "R4 pulse ends", out_valid, 0);

        // R7 with enable low, then R8 and fresh delivery
        tag_v = "R7"; tag_d = "R7";
        send(8'h77, 10, 5);
        idle(8);
        at_neg(d); en = 1'b0; rst_n = 1'b0;
        idle(3);
        check(out_valid === 1'b0 && out_data === 8'h00, "R7 reset under en low", out_data, 0);
        at_neg(d); rst_n = 1'b1; en = 1'b1;
        tag_v = "R8"; tag_d = "R8";
        p0 = pulses;
        idle(10);
        check(pulses == p0, "R8 no pulse after second reset", pulses - p0, 0);
        tag_v = "R2"; tag_d = "R1";
        send(8'h9E, 30, 30);
        idle(8);
        check(pulses - p0 == 1 && out_data === 8'h9E, "R1 byte after reset", out_data, 8'h9E);
        report();
    end
endmodule